// File: doc/BRIEF.md
# Single-Address DMA Handshake Sequencer

This block runs one single-address DMA bus cycle. In such a cycle, data moves directly between a memory and a peripheral device, and each side has its own way of ending the cycle. The memory ends it with an active-low acknowledge (`mem_ack_n`). The peripheral can also hold the cycle open with an active-low ready (`dev_rdy_n`), but only when the ready mode is enabled. The sequencer drives five things: the address strobe, the data strobe, two write-enable lanes, and the device acknowledge. It closes the cycle only after it has recognized every enabled termination source. It also raises a one-clock completion pulse in the final clock, while the strobes are still asserted. Logic outside the block can use this pulse as a certain end-of-transfer mark, without having to combine both termination sources itself.

Both acknowledge inputs are sampled once per clock. A source counts as recognized from the first sampled clock on which it is low. The cycle ends `TAIL_CLKS` (two) clocks after the last enabled source is recognized. Some inputs are captured when a start is accepted and held for the whole cycle:
- the direction (`rd_nwr`, 1 = memory read, device write);
- the ready-enable mode bit;
- the delayed-acknowledge mode bit.

The state machine has three states:
- **IDLE**: all strobes are negated. The transition **IDLE→RUN** is taken when `start` is high.
- **RUN**: the address strobe is asserted and the termination sources are collected. The transition **RUN→TAIL** is taken in the clock where the memory acknowledge and, if enabled, the ready have both been recognized.
- **TAIL**: a down-counter of `TAIL_CLKS` clocks runs. The completion pulse is high in its last clock. The transition **TAIL→IDLE** is taken when the counter reaches zero.

Top module: `dmahs_seq`

## Requirements
- R1: After reset, all active-low outputs are high and `xfer_done` is low.
- R2: A start is accepted only in IDLE, and the address strobe asserts in the next clock. While a cycle is running, a `start` pulse, a change of direction and a change of the mode inputs have no effect on that cycle. No second cycle follows.
- R3: With ready disabled, let clock 1 be the first clock with the address strobe asserted, and let the memory acknowledge first be sampled low at the end of clock i. The address strobe is then asserted for exactly i+2 clocks.
- R4: With ready enabled, a ready sampled low in clock 1 (for example, one held over from the previous transfer) gives a 3-clock cycle. A ready first sampled low in clock 2 gives a 4-clock cycle, provided the memory acknowledge is already low.
- R5: With ready enabled, the cycle length is 2 plus the clock number of whichever of the two sources is recognized later. If ready arrives first, the cycle is stretched until the memory acknowledge also arrives.
- R6: On a write (`rd_nwr`=0), the data strobe and both write enables assert together. They assert from clock 2 when ready is disabled, and from the clock after ready is recognized when ready is enabled. They then stay asserted until the cycle ends.
- R7: On a read (`rd_nwr`=1), the data strobe asserts with the address strobe from clock 1, and neither write enable ever asserts.
- R8: On a read with delayed acknowledge (`dly_ack_en`=1), the device acknowledge stays high until the clock after the memory acknowledge is recognized.
- R9: When the delayed-acknowledge mode is off, or on any write, the device acknowledge asserts together with the address strobe from clock 1.
- R10: `xfer_done` is high for exactly one clock, the last clock in which the address strobe is asserted. In the next clock, all strobes, write enables and the device acknowledge are negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the acknowledge inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a cycle (used only in IDLE) |
| rd_nwr | input | 1 | Direction: 1 = memory read to device, 0 = device write to memory |
| rdy_en | input | 1 | Mode: device ready takes part in termination |
| dly_ack_en | input | 1 | Mode: delayed device acknowledge on reads |
| mem_ack_n | input | 1 | Memory acknowledge, active low |
| dev_rdy_n | input | 1 | Device ready, active low |
| addr_stb_n | output | 1 | Address strobe, active low |
| data_stb_n | output | 1 | Data strobe, active low |
| wr_en_hi_n | output | 1 | Upper-lane write enable, active low |
| wr_en_lo_n | output | 1 | Lower-lane write enable, active low |
| dev_ack_n | output | 1 | Device acknowledge, active low |
| xfer_done | output | 1 | One-clock transfer-complete pulse |

## Verification
The hardest case to reach is a busy-time disturbance: a second `start` arriving during RUN with the opposite direction and ready enabled, at a moment when the device ready is high. A faulty design would then either restart or wait forever for ready. The stimulus creates this case by pulsing `start` in clock 2 of a read that is ended only by the memory acknowledge. It then checks two things: the cycle length still follows the captured settings, and the address strobe stays negated for two clocks afterwards. The other ordering cases are reached by placing the first low clock of each termination source independently, including ready before memory and memory before ready.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic rd;
        logic rdy_en;
        logic dly_ack;
    } cyc_cfg_t;

endpackage

// File: rtl/dmahs_term_track.sv
module dmahs_term_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic rdy_en,
    input  logic mem_ack_n,
    input  logic dev_rdy_n,
    output logic mem_seen,
    output logic rdy_seen,
    output logic all_now
);
    logic mem_q, rdy_q;
    logic mem_now, rdy_now;

    // A source is recognized from the first sample taken low; once seen it stays seen.
    always_comb begin
        mem_now = mem_q || !mem_ack_n;
        rdy_now = !rdy_en || rdy_q || !dev_rdy_n;
        all_now = mem_now && rdy_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= 1'b0;
            rdy_q <= 1'b0;
        end else if (clear) begin
            mem_q <= 1'b0;
            rdy_q <= 1'b0;
        end else if (sample) begin
            mem_q <= mem_now;
            rdy_q <= rdy_now;
        end
    end

    assign mem_seen = mem_q;
    assign rdy_seen = rdy_q;
endmodule

// File: rtl/dmahs_strobe_dec.sv
module dmahs_strobe_dec
    import dmahs_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  seq_state_t       state,
    input  cyc_cfg_t         cfg,
    input  logic             first,
    input  logic             mem_seen,
    input  logic             rdy_seen,
    input  logic [CNT_W-1:0] tail_cnt,
    output logic             as_on,
    output logic             ds_on,
    output logic             we_on,
    output logic             dack_on,
    output logic             done_on
);
    logic active;
    logic wr_ok;

    always_comb begin
        active  = (state != ST_IDLE);
        // Write data must be valid before memory is strobed: skip clock 1, and wait for ready if enabled.
        wr_ok   = !first && (!cfg.rdy_en || rdy_seen);
        as_on   = active;
        ds_on   = active && (cfg.rd || wr_ok);
        we_on   = active && !cfg.rd && wr_ok;
        dack_on = active && (!(cfg.rd && cfg.dly_ack) || mem_seen);
        done_on = (state == ST_TAIL) && (tail_cnt == '0);
    end
endmodule

// File: rtl/dmahs_seq.sv
module dmahs_seq
    import dmahs_pkg::*;
#(
    parameter int TAIL_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_nwr,
    input  logic rdy_en,
    input  logic dly_ack_en,
    input  logic mem_ack_n,
    input  logic dev_rdy_n,
    output logic addr_stb_n,
    output logic data_stb_n,
    output logic wr_en_hi_n,
    output logic wr_en_lo_n,
    output logic dev_ack_n,
    output logic xfer_done
);
    localparam int CNT_W = (TAIL_CLKS < 2) ? 1 : $clog2(TAIL_CLKS);
    localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_CLKS - 1);

    seq_state_t       state_q, state_d;
    cyc_cfg_t         cfg_q;
    logic             first_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic             mem_seen, rdy_seen, all_now;
    logic             as_on, ds_on, we_on, dack_on, done_on;
    logic             cur_rd, cur_rdy_en, cur_dly;

    assign accept = (state_q == ST_IDLE) && start;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)          state_d = ST_RUN;
            ST_RUN:  if (all_now)        state_d = ST_TAIL;
            ST_TAIL: if (cnt_q == '0)    state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // State register with cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            first_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            first_q <= accept;
            if (accept) begin
                cfg_q <= '{rd: rd_nwr, rdy_en: rdy_en, dly_ack: dly_ack_en};
            end
            if (state_q == ST_RUN && all_now) begin
                cnt_q <= TAIL_LOAD;
            end else if (state_q == ST_TAIL && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    dmahs_term_track i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample    (state_q == ST_RUN),
        .rdy_en    (cfg_q.rdy_en),
        .mem_ack_n (mem_ack_n),
        .dev_rdy_n (dev_rdy_n),
        .mem_seen  (mem_seen),
        .rdy_seen  (rdy_seen),
        .all_now   (all_now)
    );

    dmahs_strobe_dec #(.CNT_W(CNT_W)) i_dec (
        .state    (state_q),
        .cfg      (cfg_q),
        .first    (first_q),
        .mem_seen (mem_seen),
        .rdy_seen (rdy_seen),
        .tail_cnt (cnt_q),
        .as_on    (as_on),
        .ds_on    (ds_on),
        .we_on    (we_on),
        .dack_on  (dack_on),
        .done_on  (done_on)
    );

    // Output drive
    always_comb begin
        addr_stb_n = !as_on;
        data_stb_n = !ds_on;
        wr_en_hi_n = !we_on;
        wr_en_lo_n = !we_on;
        dev_ack_n  = !dack_on;
        xfer_done  = done_on;
    end

    assign cur_rd     = cfg_q.rd;
    assign cur_rdy_en = cfg_q.rdy_en;
    assign cur_dly    = cfg_q.dly_ack;
endmodule

// File: rtl/dmahs_seq_chk.sv
module dmahs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic addr_stb_n,
    input logic data_stb_n,
    input logic wr_en_hi_n,
    input logic wr_en_lo_n,
    input logic dev_ack_n,
    input logic xfer_done,
    input logic cur_rd,
    input logic cur_rdy_en,
    input logic cur_dly,
    input logic mem_seen,
    input logic rdy_seen
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && addr_stb_n) |=> !addr_stb_n);

    p_done_needs_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> mem_seen);

    p_wr_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_lo_n && cur_rdy_en) |-> rdy_seen);

    p_lanes_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_hi_n == wr_en_lo_n);

    p_ds_inside_as_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_stb_n |-> !addr_stb_n);

    p_read_no_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_stb_n && cur_rd) |-> (wr_en_hi_n && wr_en_lo_n));

    p_dly_read_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ack_n && cur_rd && cur_dly) |-> mem_seen);

    p_ack_with_as_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_stb_n && !(cur_rd && cur_dly)) |-> !dev_ack_n);

    p_done_inside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !addr_stb_n);

    p_done_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (addr_stb_n && data_stb_n && wr_en_hi_n && dev_ack_n && !xfer_done));
endmodule

bind dmahs_seq dmahs_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .addr_stb_n (addr_stb_n),
    .data_stb_n (data_stb_n),
    .wr_en_hi_n (wr_en_hi_n),
    .wr_en_lo_n (wr_en_lo_n),
    .dev_ack_n  (dev_ack_n),
    .xfer_done  (xfer_done),
    .cur_rd     (cur_rd),
    .cur_rdy_en (cur_rdy_en),
    .cur_dly    (cur_dly),
    .mem_seen   (mem_seen),
    .rdy_seen   (rdy_seen)
);

// File: tb/test_dmahs_seq.sv
module test_dmahs_seq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, rd_nwr = 1'b1, rdy_en = 1'b0, dly_ack_en = 1'b0;
    logic mem_ack_n = 1'b1, dev_rdy_n = 1'b1;
    logic addr_stb_n, data_stb_n, wr_en_hi_n, wr_en_lo_n, dev_ack_n, xfer_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmahs_seq i_dmahs_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .rdy_en(rdy_en), .dly_ack_en(dly_ack_en),
        .mem_ack_n(mem_ack_n), .dev_rdy_n(dev_rdy_n),
        .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n),
        .wr_en_hi_n(wr_en_hi_n), .wr_en_lo_n(wr_en_lo_n),
        .dev_ack_n(dev_ack_n), .xfer_done(xfer_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one cycle; memory ack goes low from clock mclk, ready from clock rclk.
    // With poke set, a start with opposite direction and ready enabled arrives in clock 2.
    task automatic run_xfer(input bit rd, input bit ren, input bit dly,
                            input int mclk, input int rclk, input bit poke,
                            input string tag);
        int len = 0, ds_first = 0, ds_cnt = 0, we_first = 0, we_cnt = 0;
        int dack_first = 0, done_clk = 0, done_cnt = 0, lane_bad = 0;
        int exp_len, exp_ds, exp_dack, late;
        @(negedge clk);
        rd_nwr = rd; rdy_en = ren; dly_ack_en = dly;
        mem_ack_n = 1'b1; dev_rdy_n = !(rclk <= 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            if (addr_stb_n) begin
                len = k - 1;
                break;
            end
            if (!data_stb_n) begin ds_cnt++; if (ds_first == 0) ds_first = k; end
            if (!wr_en_lo_n) begin we_cnt++; if (we_first == 0) we_first = k; end
            if (wr_en_hi_n != wr_en_lo_n) lane_bad++;
            if (!dev_ack_n && dack_first == 0) dack_first = k;
            if (xfer_done) begin done_cnt++; done_clk = k; end
            mem_ack_n = !(k >= mclk);
            dev_rdy_n = !(k >= rclk);
            if (poke && k == 2) begin
                start = 1'b1; rd_nwr = !rd; rdy_en = 1'b1; dly_ack_en = !dly;
            end
            if (poke && k == 3) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        // Clock len+1: everything negated, no extra pulse.
        check(data_stb_n && wr_en_hi_n && wr_en_lo_n && dev_ack_n && !xfer_done,
              {tag, " R10 idle after done"}, {data_stb_n, wr_en_lo_n, dev_ack_n, xfer_done}, 4'b1110);
        mem_ack_n = 1'b1; dev_rdy_n = 1'b1;
        late = (ren && rclk > mclk) ? rclk : mclk;
        exp_len = late + 2;
        check(len == exp_len, {tag, ren ? " R4/R5 length" : " R3 length"}, len, exp_len);
        exp_ds = rd ? 1 : (ren ? ((rclk + 1 < 2) ? 2 : rclk + 1) : 2);
        check(ds_first == exp_ds, {tag, rd ? " R7 ds start" : " R6 ds start"}, ds_first, exp_ds);
        check(ds_cnt == len - exp_ds + 1, {tag, " R6 ds held"}, ds_cnt, len - exp_ds + 1);
        if (rd) check(we_cnt == 0, {tag, " R7 no write enable"}, we_cnt, 0);
        else    check(we_first == exp_ds && we_cnt == ds_cnt && lane_bad == 0,
                      {tag, " R6 write enables"}, we_first, exp_ds);
        exp_dack = (rd && dly) ? mclk + 1 : 1;
        check(dack_first == exp_dack, {tag, (rd && dly) ? " R8 dack delay" : " R9 dack with as"},
              dack_first, exp_dack);
        check(done_cnt == 1 && done_clk == len, {tag, " R10 done last clock"}, done_clk, len);
        if (poke) begin
            @(negedge clk);
            check(addr_stb_n == 1'b1, {tag, " R2 no restart"}, addr_stb_n, 1);
            @(negedge clk);
            check(addr_stb_n == 1'b1, {tag, " R2 still idle"}, addr_stb_n, 1);
        end
    endtask

    task automatic t_reset();
        check(addr_stb_n && data_stb_n && wr_en_hi_n && wr_en_lo_n && dev_ack_n && !xfer_done,
              "R1 reset state", {addr_stb_n, data_stb_n, dev_ack_n, xfer_done}, 4'b1110);
    endtask

    task automatic t_start_latency();
        @(negedge clk);
        rd_nwr = 1'b1; rdy_en = 1'b0; dly_ack_en = 1'b0; start = 1'b1;
        check(addr_stb_n == 1'b1, "R2 idle before edge", addr_stb_n, 1);
        @(negedge clk);
        start = 1'b0;
        check(addr_stb_n == 1'b0, "R2 as after start", addr_stb_n, 0);
        mem_ack_n = 1'b0;
        repeat (4) @(negedge clk);
        mem_ack_n = 1'b1;
    endtask

    task automatic t_read_plain();      run_xfer(1, 0, 0, 1, 99, 0, "rd plain");      endtask
    task automatic t_read_waits();      run_xfer(1, 0, 0, 4, 99, 0, "rd wait");       endtask
    task automatic t_write_plain();     run_xfer(0, 0, 0, 2, 99, 0, "wr plain");      endtask
    task automatic t_read_rdy_held();   run_xfer(1, 1, 0, 1, 1, 0, "rd rdy held");    endtask
    task automatic t_read_rdy_clk2();   run_xfer(1, 1, 0, 1, 2, 0, "rd rdy clk2");    endtask
    task automatic t_write_rdy_late();  run_xfer(0, 1, 0, 1, 4, 0, "wr rdy late");    endtask
    task automatic t_rdy_before_mem();  run_xfer(0, 1, 0, 5, 1, 0, "rdy first");      endtask
    task automatic t_read_dly();        run_xfer(1, 0, 1, 3, 99, 0, "rd dly");        endtask
    task automatic t_read_dly_rdy();    run_xfer(1, 1, 1, 2, 3, 0, "rd dly rdy");     endtask
    task automatic t_write_dly_rdy();   run_xfer(0, 1, 1, 3, 2, 0, "wr dly rdy");     endtask
    task automatic t_busy_poke();       run_xfer(1, 0, 0, 3, 99, 1, "busy");          endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_latency();
        t_read_plain();
        t_read_waits();
        t_write_plain();
        t_read_rdy_held();
        t_read_rdy_clk2();
        t_write_rdy_late();
        t_rdy_before_mem();
        t_read_dly();
        t_read_dly_rdy();
        t_write_dly_rdy();
        t_busy_poke();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule